// File: doc/BRIEF.md
# Per-Channel Line Change Interrupt

This block watches four line inputs on each of a set of channels and raises one shared, active-low interrupt request when any of them changes level. Two of the four inputs per channel arrive already filtered; the other two come straight from bidirectional pins. A pin of this second kind only counts as a source while its direction control says it is an input. Every source triggers on both rising and falling edges. A per-channel 4-bit enable field decides which sources may record an event. A recorded event is held in a sticky flag until software reads that channel's status.

Status reads use a valid/ready request stream that carries a channel number, and a valid/ready response stream that returns the channel number and its four flags. A request is accepted in a cycle where `req_valid` and `req_ready` are both high. In that same cycle, all four flags of the named channel are cleared together. The response register holds one entry. It keeps its contents unchanged while `rsp_valid` is high and `rsp_ready` is low, and `req_ready` stays low until that entry is taken, so back-pressure on the response side stalls the request side. The filtering of the inputs and the register bank that drives the pins are outside this block.

Top module: `line_chg_irq`

## Requirements
- R1: A level change in either direction on a filtered input (flag bit 0 for input A, bit 1 for input B) sets that flag at the first clock edge after the change.
- R2: A bidirectional pin whose direction bit is 1 (input) sets its flag on either edge. Pin A uses flag bit 2 and pin B uses flag bit 3.
- R3: While a bidirectional pin's direction bit is 0 (output), level changes on that pin set no flag.
- R4: Turning a pin from output to input does not record an event, even if its level differs from the level it had while it was an output. The edge reference is reloaded on the turnaround.
- R5: The enable field of channel c is `irq_en[4c+3:4c]`, and its bit order matches the flag bits. A change on a source whose enable bit is 0 sets no flag.
- R6: `irq_n` is low exactly while some channel holds a flag whose enable bit is currently 1. A flag whose enable was cleared afterwards stays held but does not drive `irq_n`.
- R7: An accepted status read returns that channel's four flags as they stood before the read. It clears all four of them, and no other channel is affected.
- R8: A source edge that arrives in the same cycle as an accepted read of its channel stays pending. It is absent from that read's response and appears in the next read.
- R9: While `rsp_valid` is high and `rsp_ready` is low, `rsp_ch` and `rsp_flags` hold steady and `req_ready` is low. A request that is not accepted clears nothing.
- R10: After reset, no flag is set, `irq_n` is high and `rsp_valid` is low, and no event is recorded from the reset values alone.
- R11: Several sources that change in the same cycle are all recorded together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| din_a | input | NCH | Filtered line input A, one bit per channel |
| din_b | input | NCH | Filtered line input B, one bit per channel |
| bio_a | input | NCH | Raw level of bidirectional pin A per channel |
| bio_b | input | NCH | Raw level of bidirectional pin B per channel |
| bio_a_in | input | NCH | Direction of pin A, 1 = input |
| bio_b_in | input | NCH | Direction of pin B, 1 = input |
| irq_en | input | 4*NCH | Per-channel source enables, channel c at [4c+3:4c] |
| req_valid | input | 1 | Status read request valid |
| req_ready | output | 1 | Status read request accepted when high with valid |
| req_ch | input | CHW | Channel to read and clear |
| rsp_valid | output | 1 | Status response valid |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_ch | output | CHW | Channel of the response |
| rsp_flags | output | 4 | Flags of that channel before clearing |
| irq_n | output | 1 | Active-low combined interrupt request |

## Verification
A flag can be set by a new edge and cleared by a status read in the same cycle. The bench provokes this by toggling a second source on channel 7 in the very cycle that a read of channel 7 is accepted. It then expects the response to hold only the older flag, `irq_n` to stay low, and a following read to return the new flag. A further case holds `rsp_ready` low with a second request waiting. This checks that the response stays frozen, that the waiting channel keeps its flag, and that the release cycle both hands over the held response and accepts the next request.

// File: rtl/lci_pkg.sv
package lci_pkg;
  localparam int NSRC = 4;

  typedef enum int unsigned {
    SRC_DIN_A = 0,
    SRC_DIN_B = 1,
    SRC_BIO_A = 2,
    SRC_BIO_B = 3
  } src_idx_e;

  typedef logic [NSRC-1:0] src_vec_t;
endpackage

// File: rtl/lci_edge_det.sv
module lci_edge_det (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  input  logic is_in,
  output logic evt
);
  logic ref_q;
  logic armed_q;

  // Reference follows the pin every cycle; arming follows direction, so a
  // pin that just became an input compares against its own current level.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_q   <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      ref_q   <= lvl;
      armed_q <= is_in;
    end
  end

  assign evt = armed_q & is_in & (lvl ^ ref_q);

  // R4: the first cycle as input never reports a change
  a_r4_no_turnaround_evt: assert property (@(posedge clk) disable iff (!rst_n)
    (is_in && !$past(is_in)) |-> !evt);
endmodule

// File: rtl/lci_chan.sv
module lci_chan
  import lci_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  src_vec_t lvl,
  input  src_vec_t is_in,
  input  src_vec_t en,
  input  logic     clr,
  output src_vec_t flags,
  output logic     pend
);
  src_vec_t evt;
  src_vec_t set_v;
  src_vec_t flags_q;

  for (genvar s = 0; s < NSRC; s++) begin : g_src
    lci_edge_det i_det (
      .clk  (clk),
      .rst_n(rst_n),
      .lvl  (lvl[s]),
      .is_in(is_in[s]),
      .evt  (evt[s])
    );
  end

  assign set_v = evt & en;

  // Clear first, then set: a same-cycle edge survives the read.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= (flags_q & ~{NSRC{clr}}) | set_v;
  end

  assign flags = flags_q;
  assign pend  = |(flags_q & en);

  // R5: a flag only rises for a source that was enabled
  a_r5_rise_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
    ((flags_q & ~$past(flags_q) & ~$past(en)) == '0));
  // R7: a clearing read leaves only the bits set in that same cycle
  a_r7_clear_all: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> ((flags_q & ~$past(set_v)) == '0));
  // R8: without a read, held flags stay held
  a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> ((flags_q & $past(flags_q)) == $past(flags_q)));
endmodule

// File: rtl/lci_rd_port.sv
module lci_rd_port
  import lci_pkg::*;
#(
  parameter int NCH = 8,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      req_valid,
  output logic                      req_ready,
  input  logic [CHW-1:0]            req_ch,
  input  logic [NCH-1:0][NSRC-1:0]  flags_all,
  output logic [NCH-1:0]            clr_vec,
  output logic                      rsp_valid,
  input  logic                      rsp_ready,
  output logic [CHW-1:0]            rsp_ch,
  output logic [NSRC-1:0]           rsp_flags
);
  logic            accept;
  logic            ch_ok;
  logic            rsp_valid_q;
  logic [CHW-1:0]  rsp_ch_q;
  src_vec_t        rsp_flags_q;
  src_vec_t        sel_flags;

  assign req_ready = !rsp_valid_q || rsp_ready;
  assign accept    = req_valid && req_ready;
  assign ch_ok     = {1'b0, req_ch} < (CHW+1)'(NCH);
  assign sel_flags = ch_ok ? flags_all[req_ch] : '0;

  for (genvar c = 0; c < NCH; c++) begin : g_clr
    assign clr_vec[c] = accept && (req_ch == CHW'(c));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid_q <= 1'b0;
      rsp_ch_q    <= '0;
      rsp_flags_q <= '0;
    end else if (accept) begin
      rsp_valid_q <= 1'b1;
      rsp_ch_q    <= req_ch;
      rsp_flags_q <= sel_flags;
    end else if (rsp_ready) begin
      rsp_valid_q <= 1'b0;
    end
  end

  assign rsp_valid = rsp_valid_q;
  assign rsp_ch    = rsp_ch_q;
  assign rsp_flags = rsp_flags_q;

  // R9: a stalled response is frozen
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_ch) && $stable(rsp_flags)));
  // R7: a read touches at most one channel
  a_r7_one_chan: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(clr_vec));
endmodule

// File: rtl/line_chg_irq.sv
module line_chg_irq
  import lci_pkg::*;
#(
  parameter int NCH = 8,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCH-1:0]    din_a,
  input  logic [NCH-1:0]    din_b,
  input  logic [NCH-1:0]    bio_a,
  input  logic [NCH-1:0]    bio_b,
  input  logic [NCH-1:0]    bio_a_in,
  input  logic [NCH-1:0]    bio_b_in,
  input  logic [4*NCH-1:0]  irq_en,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [CHW-1:0]    req_ch,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [CHW-1:0]    rsp_ch,
  output logic [3:0]        rsp_flags,
  output logic              irq_n
);
  logic [NCH-1:0][NSRC-1:0] flags_all;
  logic [NCH-1:0]           clr_vec;
  logic [NCH-1:0]           pend_vec;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    src_vec_t lvl_c;
    src_vec_t dir_c;
    assign lvl_c[SRC_DIN_A] = din_a[c];
    assign lvl_c[SRC_DIN_B] = din_b[c];
    assign lvl_c[SRC_BIO_A] = bio_a[c];
    assign lvl_c[SRC_BIO_B] = bio_b[c];
    assign dir_c[SRC_DIN_A] = 1'b1;
    assign dir_c[SRC_DIN_B] = 1'b1;
    assign dir_c[SRC_BIO_A] = bio_a_in[c];
    assign dir_c[SRC_BIO_B] = bio_b_in[c];

    lci_chan i_chan (
      .clk  (clk),
      .rst_n(rst_n),
      .lvl  (lvl_c),
      .is_in(dir_c),
      .en   (irq_en[NSRC*c +: NSRC]),
      .clr  (clr_vec[c]),
      .flags(flags_all[c]),
      .pend (pend_vec[c])
    );
  end

  lci_rd_port #(.NCH(NCH)) i_rd (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_valid(req_valid),
    .req_ready(req_ready),
    .req_ch   (req_ch),
    .flags_all(flags_all),
    .clr_vec  (clr_vec),
    .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready),
    .rsp_ch   (rsp_ch),
    .rsp_flags(rsp_flags)
  );

  assign irq_n = ~(|pend_vec);

  // R6: a low request always has a held flag behind it
  a_r6_irq_has_flag: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_n |-> (|flags_all));
  // R10: nothing pending right after reset release
  a_r10_quiet_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (irq_n && !rsp_valid));
endmodule

// File: tb/test_line_chg_irq.sv
module test_line_chg_irq;
  localparam int NCH = 8;
  localparam int CHW = 3;

  logic             clk = 1'b0;
  logic             rst_n;
  logic [NCH-1:0]   din_a, din_b, bio_a, bio_b, bio_a_in, bio_b_in;
  logic [4*NCH-1:0] irq_en;
  logic             req_valid, req_ready, rsp_valid, rsp_ready, irq_n;
  logic [CHW-1:0]   req_ch, rsp_ch;
  logic [3:0]       rsp_flags;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;
  logic [CHW+3:0] exp_q[$];

  always #5 clk = ~clk;

  line_chg_irq #(.NCH(NCH)) i_line_chg_irq (
    .clk(clk), .rst_n(rst_n),
    .din_a(din_a), .din_b(din_b), .bio_a(bio_a), .bio_b(bio_b),
    .bio_a_in(bio_a_in), .bio_b_in(bio_b_in), .irq_en(irq_en),
    .req_valid(req_valid), .req_ready(req_ready), .req_ch(req_ch),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_ch(rsp_ch),
    .rsp_flags(rsp_flags), .irq_n(irq_n)
  );

  task automatic chk(string tag, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  task automatic drv_sync();
    @(posedge clk); #1;
  endtask

  task automatic settle();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic do_read(int ch, logic [3:0] exp);
    exp_q.push_back({CHW'(ch), exp});
    drv_sync();
    req_valid = 1'b1; req_ch = CHW'(ch);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    drv_sync();
    req_valid = 1'b0;
    @(negedge clk);
  endtask

  // Monitor: pops the scoreboard on every response handshake
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && rsp_valid && rsp_ready) begin
        if (exp_q.size() == 0) chk("R7 unexpected response", 1, 0);
        else begin
          logic [CHW+3:0] e;
          e = exp_q.pop_front();
          chk("R7 response ch/flags", int'({rsp_ch, rsp_flags}), int'(e));
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 0;
    din_a = '0; din_b = '0; bio_a = '0; bio_b = '0;
    bio_a_in = '1; bio_b_in = '1; irq_en = '0;
    req_valid = 0; req_ch = '0; rsp_ready = 1;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk("R10 irq_n after reset", int'(irq_n), 1);
    chk("R10 rsp_valid after reset", int'(rsp_valid), 0);
    drv_sync(); irq_en = '1;
    repeat (3) @(negedge clk);
    chk("R10 no event from reset", int'(irq_n), 1);

    // R1 rising then falling edge, R6 irq
    drv_sync(); din_a[0] = 1; settle();
    chk("R1 rise sets irq", int'(irq_n), 0);
    do_read(0, 4'b0001);
    chk("R7 irq released after read", int'(irq_n), 1);
    drv_sync(); din_a[0] = 0; settle();
    do_read(0, 4'b0001);

    // R11 + R2 simultaneous sources
    drv_sync(); din_b[1] = 1; bio_a[1] = 1; bio_b[1] = 1; settle();
    do_read(1, 4'b1110);

    // R3 output pin ignored, R4 turnaround quiet, R2 then counts
    drv_sync(); bio_a_in[2] = 0; settle();
    drv_sync(); bio_a[2] = 1; settle(); @(negedge clk);
    chk("R3 output pin ignored", int'(irq_n), 1);
    drv_sync(); bio_a_in[2] = 1; settle(); @(negedge clk);
    chk("R4 turnaround no event", int'(irq_n), 1);
    drv_sync(); bio_a[2] = 0; settle();
    do_read(2, 4'b0100);

    // R5 disabled source
    drv_sync(); irq_en[15:12] = 4'b1110; din_a[3] = 1; settle();
    chk("R5 disabled source no irq", int'(irq_n), 1);
    do_read(3, 4'b0000);
    drv_sync(); din_b[3] = 1; settle();
    do_read(3, 4'b0010);

    // R6 enable cleared after flag set
    drv_sync(); din_a[4] = 1; settle();
    drv_sync(); irq_en[19:16] = 4'b0000; @(negedge clk);
    chk("R6 masked flag releases irq", int'(irq_n), 1);
    do_read(4, 4'b0001);
    drv_sync(); irq_en[19:16] = 4'b1111;

    // R7 only the read channel clears
    drv_sync(); din_a[5] = 1; din_b[6] = 1; settle();
    do_read(5, 4'b0001);
    chk("R7 other channel still pending", int'(irq_n), 0);
    do_read(6, 4'b0010);
    chk("R7 all cleared", int'(irq_n), 1);

    // R8 edge during clearing read
    drv_sync(); din_a[7] = 1; settle();
    exp_q.push_back({CHW'(7), 4'b0001});
    drv_sync(); req_valid = 1; req_ch = 3'd7; din_b[7] = 1;
    drv_sync(); req_valid = 0;
    @(negedge clk);
    chk("R8 same-cycle edge keeps irq", int'(irq_n), 0);
    do_read(7, 4'b0010);
    chk("R8 cleared afterwards", int'(irq_n), 1);

    // R9 back-pressure
    drv_sync(); rsp_ready = 0; din_a[0] = 1; din_a[1] = 1; settle();
    exp_q.push_back({CHW'(0), 4'b0001});
    drv_sync(); req_valid = 1; req_ch = 3'd0;
    drv_sync(); req_ch = 3'd1;
    @(negedge clk);
    chk("R9 req_ready low while stalled", int'(req_ready), 0);
    chk("R9 held flags", int'(rsp_flags), 1);
    repeat (2) @(negedge clk);
    chk("R9 held channel stable", int'(rsp_ch), 0);
    chk("R9 unaccepted read clears nothing", int'(irq_n), 0);
    exp_q.push_back({CHW'(1), 4'b0001});
    drv_sync(); rsp_ready = 1;
    drv_sync(); req_valid = 0;
    @(negedge clk); @(negedge clk);
    chk("R9 both reads done", int'(irq_n), 1);
    chk("R7 scoreboard drained", exp_q.size(), 0);
    finish_run();
  end
endmodule